// File: doc/BRIEF.md
# DMA System Bus Master Sequencer

This block lets a peripheral take control of a shared host bus to move a run of words by DMA. Internal logic presents a word count and a direction. The block then arbitrates by raising a bus request. It takes the bus only when a synchronised grant is present and the bus-busy input reads high (not busy). Once it owns the bus, it runs one fixed four-clock cycle per word. The cycle pulses the address-latch strobe, opens the external data buffers and steers their direction. It also drives a shared control pin that carries either an active-low byte-high enable or a read-not-write flag, chosen by a mode input.

A higher-priority master can ask for the bus at any time by pulling the release input low. The block finishes the word in flight, drops its request for one clock and arbitrates again until all words are moved. Between DMA transfers, the host can make direct I/O accesses while holding chip select low. For those accesses the block drives only the buffer enable and direction. DMA requests that arrive during such an access wait until it ends.

Top module: `dma_bus_sequencer`

## Requirements
- R1: The block leaves arbitration for bus ownership only in a cycle in which the two-flop synchronised grant is high, bus_busy_n is high and no direct I/O access is active. bus_req is high exactly while arbitrating or owning the bus, and low otherwise.
- R2: Each word is moved in four consecutive clocks: address, strobe, data and end. ale is high only in the address clock, so exactly one ale pulse is produced per word.
- R3: buf_en_n is low in the strobe and data clocks of a DMA cycle and while a direct I/O access is active. It is high at all other times.
- R4: dir is 1 for DMA writes (xfer_write=1, data out of the block) and for direct I/O reads (dio_write=0). dir is 0 for DMA reads and direct I/O writes, and 1 when neither is active. During DMA it holds its value for all four clocks of every cycle.
- R5: bhe_rnw_oe is high only while the bus is owned (address to end clock). With mode_rnw=0, bhe_rnw is the inverse of the byte_high value latched with the request. With mode_rnw=1, bhe_rnw is 1 for a DMA read and 0 for a DMA write. While bhe_rnw_oe is low, bhe_rnw is 1.
- R6: bus_release_n passes through a two-flop synchroniser. If it reads low in an end clock and words remain, the block drops bus_req for one clock and then arbitrates again. In that case one bus_req fall occurs per word when release is held low, and every requested word is still moved.
- R7: bus_release_n has no effect when no DMA cycle is in progress. A low value while idle neither raises bus_req nor changes the buffer outputs. A later transfer with release high shows a single bus_req fall.
- R8: words_left is loaded from xfer_words when a request is accepted and is decremented in each end clock. xfer_done pulses for one clock after the last word. A request with xfer_words=0 is ignored.
- R9: A direct I/O access is recognised only while cs_n is low and the bus is not owned. It becomes active one clock after cs_n falls.
- R10: A DMA request made during an active direct I/O access is held off, with bus_req low, until the access ends. The DMA buffer controls and the direct I/O controls are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req | input | 1 | Transfer request from internal logic, sampled while idle |
| xfer_write | input | 1 | 1 = DMA write (out of block), 0 = DMA read |
| xfer_byte_high | input | 1 | High byte lane wanted for the transfer |
| xfer_words | input | CNT_W | Number of words to move |
| mode_rnw | input | 1 | 0 = shared pin is byte-high enable, 1 = read-not-write |
| bus_busy_n | input | 1 | High = bus not busy |
| bus_grant | input | 1 | Asynchronous grant from the bus arbiter |
| bus_release_n | input | 1 | Low = higher-priority master wants the bus |
| cs_n | input | 1 | Active-low chip select for direct I/O |
| dio_write | input | 1 | 1 = direct I/O write into the block |
| bus_req | output | 1 | Bus request to the arbiter |
| ale | output | 1 | Address-latch strobe |
| bhe_rnw | output | 1 | Byte-high enable or read-not-write value |
| bhe_rnw_oe | output | 1 | Output enable for bhe_rnw |
| buf_en_n | output | 1 | Active-low external data buffer enable |
| dir | output | 1 | Buffer direction, 1 = out of block |
| words_left | output | CNT_W | Words still to move |
| xfer_done | output | 1 | One-clock pulse after the last word |

## Verification
The hardest situation to reach from the ports is a release that arrives in the middle of a multi-word transfer. The request must be dropped after the word in flight and then raised again, with no word lost and no ale pulse repeated. The bench holds bus_release_n low for whole transfers, so every end clock sees it. It then checks that the count of bus_req falls equals the word count, against a single fall when release stays high. Random grant and busy noise, together with chip select driven in the middle of a transfer and before a request, push arbitration through its stall and hold-off paths.

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_req,
  input  logic             xfer_write,
  input  logic             xfer_byte_high,
  input  logic [CNT_W-1:0] xfer_words,
  input  logic             mode_rnw,
  input  logic             bus_busy_n,
  input  logic             bus_grant,
  input  logic             bus_release_n,
  input  logic             cs_n,
  input  logic             dio_write,
  output logic             bus_req,
  output logic             ale,
  output logic             bhe_rnw,
  output logic             bhe_rnw_oe,
  output logic             buf_en_n,
  output logic             dir,
  output logic [CNT_W-1:0] words_left,
  output logic             xfer_done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_ARB, S_ADDR, S_STRB, S_DATA, S_END, S_REL
  } st_t;

  st_t st, nxt;
  logic [1:0] gnt_q, rel_q;
  logic gnt_s, rel_s;
  logic dio_act, dio_wr;
  logic wr_l, bh_l;
  logic own, own_nxt;
  logic [CNT_W-1:0] cnt;

  assign gnt_s = gnt_q[1];
  assign rel_s = rel_q[1];
  assign own     = (st == S_ADDR) || (st == S_STRB) || (st == S_DATA) || (st == S_END);
  assign own_nxt = (nxt == S_ADDR) || (nxt == S_STRB) || (nxt == S_DATA) || (nxt == S_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= 2'b00;
      rel_q <= 2'b11;
    end else begin
      gnt_q <= {gnt_q[0], bus_grant};
      rel_q <= {rel_q[0], bus_release_n};
    end
  end

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (xfer_req && (xfer_words != '0) && !dio_act) nxt = S_ARB;
      S_ARB:  if (gnt_s && bus_busy_n && !dio_act) nxt = S_ADDR;
      S_ADDR: nxt = S_STRB;
      S_STRB: nxt = S_DATA;
      S_DATA: nxt = S_END;
      S_END: begin
        if (cnt == ONE)  nxt = S_IDLE;
        else if (!rel_s) nxt = S_REL;
        else             nxt = S_ADDR;
      end
      S_REL:  nxt = S_ARB;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_l      <= 1'b0;
      bh_l      <= 1'b0;
      xfer_done <= 1'b0;
      dio_act   <= 1'b0;
      dio_wr    <= 1'b0;
    end else begin
      st        <= nxt;
      xfer_done <= (st == S_END) && (cnt == ONE);
      dio_act   <= !cs_n && !own_nxt;
      dio_wr    <= dio_write;
      if (st == S_IDLE && nxt == S_ARB) begin
        cnt  <= xfer_words;
        wr_l <= xfer_write;
        bh_l <= xfer_byte_high;
      end else if (st == S_END) begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign bus_req    = own || (st == S_ARB);
  assign ale        = (st == S_ADDR);
  assign bhe_rnw_oe = own;
  assign bhe_rnw    = !own ? 1'b1 : (mode_rnw ? !wr_l : !bh_l);
  assign buf_en_n   = !(((st == S_STRB) || (st == S_DATA)) || dio_act);
  assign dir        = own ? wr_l : (dio_act ? !dio_wr : 1'b1);
  assign words_left = cnt;

  AST_ARB_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bhe_rnw_oe) |-> ($past(bus_busy_n) && $past(gnt_s))); // R1

  AST_ALE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (bus_req && bhe_rnw_oe && buf_en_n)); // R2

  AST_ALE_THEN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !buf_en_n); // R3

  AST_IDLE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!bhe_rnw_oe && !dio_act) |-> dir); // R4

  AST_PIN_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !bhe_rnw_oe |-> bhe_rnw); // R5

  AST_REL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_END) && !rel_s && (cnt != ONE)) |=> !bus_req); // R6

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_END) |=> (words_left == $past(words_left) - ONE)); // R8

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(dio_act && bhe_rnw_oe)); // R10

endmodule

// File: tb/dma_bus_sequencer_test.sv
`timescale 1ns/1ps
module dma_bus_sequencer_test;
  localparam int CNT_W = 8;

  logic clk = 0, rst_n = 0;
  logic xfer_req = 0, xfer_write = 0, xfer_byte_high = 0, mode_rnw = 0;
  logic [CNT_W-1:0] xfer_words = '0;
  logic bus_busy_n = 1, bus_grant = 0, bus_release_n = 1, cs_n = 1, dio_write = 0;
  logic bus_req, ale, bhe_rnw, bhe_rnw_oe, buf_en_n, dir, xfer_done;
  logic [CNT_W-1:0] words_left;

  dma_bus_sequencer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_write(xfer_write),
    .xfer_byte_high(xfer_byte_high), .xfer_words(xfer_words), .mode_rnw(mode_rnw),
    .bus_busy_n(bus_busy_n), .bus_grant(bus_grant), .bus_release_n(bus_release_n),
    .cs_n(cs_n), .dio_write(dio_write), .bus_req(bus_req), .ale(ale),
    .bhe_rnw(bhe_rnw), .bhe_rnw_oe(bhe_rnw_oe), .buf_en_n(buf_en_n), .dir(dir),
    .words_left(words_left), .xfer_done(xfer_done));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int ale_cnt = 0, done_cnt = 0, falls = 0, mon_err = 0;
  logic prev_req = 0;
  logic exp_wr = 0, exp_bh = 0;
  logic noise = 0, gate_en = 1;
  int unsigned seed_dummy;

  function automatic logic exp_pin(logic m, logic wr, logic bh);
    return m ? !wr : !bh;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) bus_grant <= bus_req & gate_en;

  always @(negedge clk) begin
    if (noise) begin
      gate_en    = ($urandom % 4) != 0;
      bus_busy_n = ($urandom % 3) != 0;
    end
    if (ale) ale_cnt++;
    if (xfer_done) done_cnt++;
    if (prev_req && !bus_req) falls++;
    prev_req = bus_req;
    if (bhe_rnw_oe) begin
      if (dir !== exp_wr) mon_err++;
      if (bhe_rnw !== exp_pin(mode_rnw, exp_wr, exp_bh)) mon_err++;
    end else if (bhe_rnw !== 1'b1) mon_err++;
    if (ale && !bhe_rnw_oe) mon_err++;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_xfer(int n, logic wr, logic bh, logic m, logic rel_low, string tag);
    int t;
    int e0;
    @(negedge clk);
    ale_cnt = 0; done_cnt = 0; falls = 0; e0 = mon_err;
    exp_wr = wr; exp_bh = bh;
    xfer_write = wr; xfer_byte_high = bh; mode_rnw = m; xfer_words = CNT_W'(n);
    bus_release_n = !rel_low;
    xfer_req = 1;
    t = 0;
    while (!bus_req && t < 2000) begin @(negedge clk); t++; end
    xfer_req = 0;
    t = 0;
    while (done_cnt == 0 && t < 4000) begin @(negedge clk); t++; end
    if (t >= 4000) begin failures++; $display("FAIL %s watchdog actual=0 expected=1", tag); end
    bus_release_n = 1;
    cyc(2);
    check({tag, " R2 ale pulses"}, ale_cnt, n);
    check({tag, " R8 done pulses"}, done_cnt, 1);
    check({tag, " R8 words_left"}, int'(words_left), 0);
    check({tag, " R6 request falls"}, falls, rel_low ? n : 1);
    check({tag, " R4 R5 monitor"}, mon_err - e0, 0);
  endtask

  initial begin
    seed_dummy = $urandom(32'h5EED_1234);
    cyc(3);
    check("R3 reset buf_en_n", buf_en_n, 1);
    check("R1 reset bus_req", bus_req, 0);
    check("R4 reset dir", dir, 1);
    check("R5 reset oe", bhe_rnw_oe, 0);
    rst_n = 1;
    cyc(3);

    cs_n = 0; dio_write = 0; cyc(2);
    check("R9 dio read buf_en_n", buf_en_n, 0);
    check("R4 dio read dir", dir, 1);
    dio_write = 1; cyc(2);
    check("R4 dio write dir", dir, 0);
    cs_n = 1; cyc(2);
    check("R9 dio end buf_en_n", buf_en_n, 1);
    check("R4 idle dir", dir, 1);

    run_xfer(4, 0, 1, 0, 0, "basic read");
    run_xfer(3, 1, 0, 1, 0, "basic write");
    run_xfer(1, 1, 1, 0, 0, "single");

    bus_busy_n = 0;
    @(negedge clk);
    xfer_words = 2; xfer_write = 0; exp_wr = 0; xfer_req = 1; ale_cnt = 0;
    cyc(3); xfer_req = 0; cyc(20);
    check("R1 busy holds req", bus_req, 1);
    check("R1 busy no ale", ale_cnt, 0);
    check("R1 busy no oe", bhe_rnw_oe, 0);
    bus_busy_n = 1; done_cnt = 0;
    cyc(30);
    check("R1 busy cleared ale", ale_cnt, 2);
    check("R8 busy cleared done", done_cnt, 1);

    run_xfer(6, 1, 0, 1, 1, "release mid");
    run_xfer(5, 0, 1, 0, 1, "release read");

    bus_release_n = 0; cyc(10);
    check("R7 idle release bus_req", bus_req, 0);
    check("R7 idle release buf_en_n", buf_en_n, 1);
    check("R7 idle release oe", bhe_rnw_oe, 0);
    bus_release_n = 1; cyc(5);
    run_xfer(3, 0, 0, 0, 0, "after idle release R7");

    xfer_words = 0; xfer_req = 1; done_cnt = 0; cyc(6); xfer_req = 0; cyc(2);
    check("R8 zero words bus_req", bus_req, 0);
    check("R8 zero words done", done_cnt, 0);

    cs_n = 0; dio_write = 0; cyc(2);
    xfer_words = 2; xfer_write = 1; exp_wr = 1; xfer_req = 1; ale_cnt = 0; done_cnt = 0;
    cyc(10);
    check("R10 deferred bus_req", bus_req, 0);
    check("R10 deferred buf_en_n", buf_en_n, 0);
    cs_n = 1; cyc(4);
    check("R10 released bus_req", bus_req, 1);
    xfer_req = 0; cyc(30);
    check("R10 deferred ale", ale_cnt, 2);

    @(negedge clk);
    xfer_words = 4; xfer_write = 0; exp_wr = 0; xfer_req = 1; ale_cnt = 0; done_cnt = 0;
    while (!bhe_rnw_oe) @(negedge clk);
    xfer_req = 0; cs_n = 0; dio_write = 1;
    while (done_cnt == 0) @(negedge clk);
    cyc(2);
    check("R9 cs during dma ale", ale_cnt, 4);
    check("R9 dio after dma buf_en_n", buf_en_n, 0);
    check("R4 dio after dma dir", dir, 0);
    cs_n = 1; cyc(3);

    noise = 1;
    for (int i = 0; i < 16; i++) begin
      int n = 1 + ($urandom % 8);
      run_xfer(n, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "random");
    end
    noise = 0; bus_busy_n = 1; gate_en = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule